// File: doc/BRIEF.md
# Power Mode Protection Controller

This block keeps the power-mode policy of a chip in two small registers on a simple register bus. The first is a protection register. It can be written once, and it says which reduced-power run mode and which leakage-saving stop modes the rest of the chip may use. The second is a control register. It selects the run mode and the stop mode. A request that the protection register does not permit is dropped, and the mode already in force stays in force. The block drives the selected run mode and stop mode straight to the power sequencer.

A third read-only register keeps the stop selection that was in force when software re-armed the protection register. Software reads it after waking to learn which stop mode the chip came out of. There are two reset inputs. The full reset clears everything. The wake-up reset keeps the deep-stop allow bits, the stop selection and the exit record, and it clears the rest.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: A full reset (`rst` high at a clock edge) clears every register. Addresses 0x0, 0x1 and 0x2 then read 0x00, and `run_mode_o` and `stop_sel_o` are 0.
- R2: The protection register sits at address 0x0. Bit 5 allows very-low-power run, bit 3 allows low-leakage stop, and bits 2, 1 and 0 allow deep stops 3, 2 and 1. The other bits read 0. The first write after a reset loads these bits, and any later write is ignored until the next reset of either kind.
- R3: The run-mode field is bits 6:5 of address 0x1. Code 00 (normal) is always accepted. Code 10 (very-low-power) is accepted only when protection bit 5 is set. Codes 01 and 11 are reserved and leave the field unchanged.
- R4: The stop selection is bits 2:0 of address 0x1. Code 000 (normal stop) is always accepted. Code 011 (low-leakage) needs protection bit 3. Codes 100, 101 and 110 (deep stops 3, 2 and 1) need protection bit 2, 1 or 0 in that order. Any other code, or a code that is not allowed, leaves the field unchanged. The run and stop fields of one write are judged independently.
- R5: An accepted protection write sets the stop selection to 000. In the same edge it copies the previous selection into the exit record, which reads at address 0x2 in bits 2:0. A protection write that is ignored changes neither.
- R6: A wake-up reset (`wake_rst` high, `rst` low) has these effects:
  - Protection bits 2:0 keep their values, and bits 5 and 3 are cleared.
  - The next protection write is accepted again.
  - The run mode returns to 00.
  - The stop selection and the exit record are kept.
- R7: Reads return register contents in the same cycle, with unused bits at 0. Unmapped addresses read 0x00, and writes to them have no effect. Writes to the exit record at 0x2 are ignored.
- R8: `run_mode_o` and `stop_sel_o` always show the current run-mode and stop-selection fields.
- R9: When `rst` and `wake_rst` are both high, the full reset takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Full synchronous reset, active high |
| wake_rst | input | 1 | Wake-up synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| run_mode_o | output | 2 | Current run mode (00 normal, 10 very-low-power) |
| stop_sel_o | output | 3 | Current stop-mode selection |

## Verification
The bench uses the default parameters:
- `ADDR_W` = 4.
- The protection register, the control register and the exit record at addresses 0, 1 and 2.

This leaves thirteen unmapped addresses, and one of them (0x5) is used to show that stray writes and reads touch nothing.

With this map, every allow bit can be made to gate its own stop code. The table drives blocked and reserved requests against a cleared protection register, then locks the register and drives the same requests again. Directed sequences cover the following:
- Wake-up resets, and re-arming the protection register after one.
- The exit record across a second wake-up.
- Both resets at once.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int DATA_W       = 8;
    localparam int RUN_W        = 2;
    localparam int STOP_W       = 3;
    localparam int NUM_DEEP     = 3;
    localparam int PROT_VLP_BIT = 5;
    localparam int PROT_LL_BIT  = 3;
    localparam int CTRL_RUN_LSB = 5;

    localparam logic [RUN_W-1:0]  RUN_NORMAL  = 2'b00;
    localparam logic [RUN_W-1:0]  RUN_VLP     = 2'b10;
    localparam logic [STOP_W-1:0] STOP_NORMAL = 3'b000;
    localparam logic [STOP_W-1:0] STOP_LOWLK  = 3'b011;
    localparam logic [STOP_W-1:0] STOP_DEEP0  = 3'b100;

    typedef struct packed {
        logic                vlp;
        logic                ll;
        logic [NUM_DEEP-1:0] deep;   // [2] deep stop 3 .. [0] deep stop 1
    } prot_t;

    function automatic logic run_code_ok(input logic [RUN_W-1:0] code, input prot_t p);
        logic ok;
        case (code)
            RUN_NORMAL: ok = 1'b1;
            RUN_VLP:    ok = p.vlp;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic stop_code_ok(input logic [STOP_W-1:0] code, input prot_t p);
        logic [STOP_W-1:0]   rel;
        logic [NUM_DEEP-1:0] shifted;
        logic                ok;
        rel     = code - STOP_DEEP0;
        shifted = p.deep << rel;
        if (code == STOP_NORMAL)
            ok = 1'b1;
        else if (code == STOP_LOWLK)
            ok = p.ll;
        else if (code >= STOP_DEEP0 && rel < STOP_W'(NUM_DEEP))
            ok = shifted[NUM_DEEP-1];
        else
            ok = 1'b0;
        return ok;
    endfunction

    function automatic prot_t prot_from_bus(input logic [DATA_W-1:0] d);
        prot_t p;
        p.vlp  = d[PROT_VLP_BIT];
        p.ll   = d[PROT_LL_BIT];
        p.deep = d[NUM_DEEP-1:0];
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] prot_to_bus(input prot_t p);
        logic [DATA_W-1:0] r;
        r                 = '0;
        r[PROT_VLP_BIT]   = p.vlp;
        r[PROT_LL_BIT]    = p.ll;
        r[NUM_DEEP-1:0]   = p.deep;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_bus(input logic [RUN_W-1:0] run,
                                                      input logic [STOP_W-1:0] stop);
        logic [DATA_W-1:0] r;
        r                        = '0;
        r[CTRL_RUN_LSB +: RUN_W] = run;
        r[STOP_W-1:0]            = stop;
        return r;
    endfunction

endpackage

// File: rtl/pmc_prot_reg.sv
module pmc_prot_reg
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output prot_t             prot_q,
    output logic              accepted
);

    logic  locked;
    prot_t incoming;

    assign incoming = prot_from_bus(wr_data);
    assign accepted = wr_req && !locked && !rst && !wake_rst;

    // lock flag and the bits a wake-up reset clears
    always_ff @(posedge clk) begin
        if (rst || wake_rst) begin
            locked     <= 1'b0;
            prot_q.vlp <= 1'b0;
            prot_q.ll  <= 1'b0;
        end else if (accepted) begin
            locked     <= 1'b1;
            prot_q.vlp <= incoming.vlp;
            prot_q.ll  <= incoming.ll;
        end
    end

    // deep-stop allow bits survive a wake-up reset
    for (genvar g = 0; g < NUM_DEEP; g++) begin : g_deep
        always_ff @(posedge clk) begin
            if (rst)
                prot_q.deep[g] <= 1'b0;
            else if (accepted)
                prot_q.deep[g] <= incoming.deep[g];
        end
    end

    p_locked_hold_r2: assert property (@(posedge clk) disable iff (rst || wake_rst)
        locked |=> $stable(prot_q));

    p_wake_keep_r6: assert property (@(posedge clk) disable iff (rst)
        wake_rst |=> (prot_q.deep == $past(prot_q.deep)) && !prot_q.vlp && !prot_q.ll);

endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_rst,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wr_data,
    input  prot_t             prot,
    input  logic              prot_accepted,
    output logic [RUN_W-1:0]  run_mode,
    output logic [STOP_W-1:0] stop_sel,
    output logic [STOP_W-1:0] exit_rec
);

    logic [RUN_W-1:0]  req_run;
    logic [STOP_W-1:0] req_stop;

    assign req_run  = wr_data[CTRL_RUN_LSB +: RUN_W];
    assign req_stop = wr_data[STOP_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_mode <= RUN_NORMAL;
            stop_sel <= STOP_NORMAL;
            exit_rec <= STOP_NORMAL;
        end else if (wake_rst) begin
            run_mode <= RUN_NORMAL;
        end else if (prot_accepted) begin
            exit_rec <= stop_sel;
            stop_sel <= STOP_NORMAL;
        end else if (ctrl_we) begin
            if (run_code_ok(req_run, prot))
                run_mode <= req_run;
            if (stop_code_ok(req_stop, prot))
                stop_sel <= req_stop;
        end
    end

    p_run_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (run_mode == RUN_NORMAL) || (run_mode == RUN_VLP));

    p_vlp_blocked_r3: assert property (@(posedge clk) disable iff (rst || wake_rst)
        (ctrl_we && !prot_accepted && req_run == RUN_VLP && !prot.vlp) |=> $stable(run_mode));

    p_stop_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (stop_sel == STOP_NORMAL) || (stop_sel == STOP_LOWLK) ||
        (stop_sel >= STOP_DEEP0 && stop_sel < STOP_DEEP0 + STOP_W'(NUM_DEEP)));

    p_stop_clear_r5: assert property (@(posedge clk) disable iff (rst || wake_rst)
        prot_accepted |=> (stop_sel == STOP_NORMAL) && (exit_rec == $past(stop_sel)));

endmodule

// File: rtl/pmc_bus_port.sv
module pmc_bus_port
    import pmc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PROT_ADDR = 0,
    parameter int CTRL_ADDR = 1,
    parameter int EXIT_ADDR = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  prot_t             prot,
    input  logic [RUN_W-1:0]  run_mode,
    input  logic [STOP_W-1:0] stop_sel,
    input  logic [STOP_W-1:0] exit_rec,
    output logic              prot_we,
    output logic              ctrl_we,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_PROT = ADDR_W'(PROT_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_EXIT = ADDR_W'(EXIT_ADDR);

    assign prot_we = we && (addr == A_PROT);
    assign ctrl_we = we && (addr == A_CTRL);

    always_comb begin
        rdata = '0;
        if (addr == A_PROT)
            rdata = prot_to_bus(prot);
        else if (addr == A_CTRL)
            rdata = ctrl_to_bus(run_mode, stop_sel);
        else if (addr == A_EXIT)
            rdata[STOP_W-1:0] = exit_rec;
    end

endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PROT_ADDR = 0,
    parameter int CTRL_ADDR = 1,
    parameter int EXIT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [1:0]        run_mode_o,
    output logic [2:0]        stop_sel_o
);

    prot_t             prot_q;
    logic              prot_we, ctrl_we, prot_acc;
    logic [RUN_W-1:0]  run_mode;
    logic [STOP_W-1:0] stop_sel, exit_rec;

    pmc_bus_port #(
        .ADDR_W(ADDR_W), .PROT_ADDR(PROT_ADDR),
        .CTRL_ADDR(CTRL_ADDR), .EXIT_ADDR(EXIT_ADDR)
    ) u_port (
        .addr(bus_addr), .we(bus_we), .prot(prot_q),
        .run_mode(run_mode), .stop_sel(stop_sel), .exit_rec(exit_rec),
        .prot_we(prot_we), .ctrl_we(ctrl_we), .rdata(bus_rdata)
    );

    pmc_prot_reg u_prot (
        .clk(clk), .rst(rst), .wake_rst(wake_rst),
        .wr_req(prot_we), .wr_data(bus_wdata),
        .prot_q(prot_q), .accepted(prot_acc)
    );

    pmc_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wake_rst(wake_rst),
        .ctrl_we(ctrl_we), .wr_data(bus_wdata),
        .prot(prot_q), .prot_accepted(prot_acc),
        .run_mode(run_mode), .stop_sel(stop_sel), .exit_rec(exit_rec)
    );

    assign run_mode_o = run_mode;
    assign stop_sel_o = stop_sel;

endmodule

// File: tb/sim_pmc_mode_ctrl.sv
module sim_pmc_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wake_rst = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] run_mode_o;
    logic [2:0] stop_sel_o;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmc_mode_ctrl u0 (
        .clk(clk), .rst(rst), .wake_rst(wake_rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .run_mode_o(run_mode_o), .stop_sel_o(stop_sel_o)
    );

    // {write addr, write data, read addr, expected read, requirement}
    localparam logic [31:0] VEC [NVEC] = '{
        {4'h1, 8'h40, 4'h1, 8'h00, 8'd3},  // R3 VLP without allow
        {4'h1, 8'h20, 4'h1, 8'h00, 8'd3},  // R3 reserved 01
        {4'h1, 8'h04, 4'h1, 8'h00, 8'd4},  // R4 deep stop 3 not allowed
        {4'h1, 8'h03, 4'h1, 8'h00, 8'd4},  // R4 low-leakage not allowed
        {4'h0, 8'hFF, 4'h0, 8'h2F, 8'd2},  // R2 first write loads
        {4'h0, 8'h00, 4'h0, 8'h2F, 8'd2},  // R2 second write ignored
        {4'h1, 8'h40, 4'h1, 8'h40, 8'd3},  // R3 VLP allowed
        {4'h1, 8'h63, 4'h1, 8'h43, 8'd3},  // R3 reserved 11 kept, stop 011 taken
        {4'h1, 8'h07, 4'h1, 8'h03, 8'd4},  // R4 code 111 ignored, run 00 taken
        {4'h1, 8'h06, 4'h1, 8'h06, 8'd4},  // R4 deep stop 1 allowed
        {4'h5, 8'hFF, 4'h5, 8'h00, 8'd7},  // R7 unmapped
        {4'h2, 8'h07, 4'h2, 8'h00, 8'd7},  // R7 record read-only
        {4'h0, 8'h00, 4'h1, 8'h06, 8'd5}   // R5 ignored prot write keeps stop
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input int req);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake_rst = 1'b1;
        @(negedge clk);
        wake_rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(4'h0, 8'h00, 1);
        rd_chk(4'h1, 8'h00, 1);
        rd_chk(4'h2, 8'h00, 1);
        check(1, {6'b0, run_mode_o}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][31:28], VEC[i][27:20]);
            rd_chk(VEC[i][19:16], VEC[i][15:8], int'(VEC[i][7:0]));
        end

        // R8 outputs follow fields
        wr(4'h1, 8'h46);
        check(8, {6'b0, run_mode_o}, 8'h02);
        check(8, {5'b0, stop_sel_o}, 8'h06);

        // R6 wake-up reset
        pulse_wake();
        rd_chk(4'h0, 8'h07, 6);
        rd_chk(4'h1, 8'h06, 6);
        rd_chk(4'h2, 8'h00, 6);

        // R6 re-arm after wake, R5 clear and record
        wr(4'h0, 8'h2C);
        rd_chk(4'h0, 8'h2C, 6);
        rd_chk(4'h1, 8'h00, 5);
        rd_chk(4'h2, 8'h06, 5);
        check(5, {5'b0, stop_sel_o}, 8'h00);

        // R4 with new allow set
        wr(4'h1, 8'h44);
        rd_chk(4'h1, 8'h44, 4);
        check(8, {6'b0, run_mode_o}, 8'h02);
        wr(4'h1, 8'h05);
        rd_chk(4'h1, 8'h04, 4);

        // R6 record and deep bits survive second wake
        pulse_wake();
        rd_chk(4'h2, 8'h06, 6);
        rd_chk(4'h0, 8'h04, 6);

        // R9 both resets together
        @(negedge clk);
        rst = 1'b1;
        wake_rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wake_rst = 1'b0;
        rd_chk(4'h0, 8'h00, 9);
        rd_chk(4'h1, 8'h00, 9);
        rd_chk(4'h2, 8'h00, 9);
        check(1, {5'b0, stop_sel_o}, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule